// File: doc/BRIEF.md
# Three-Channel Timer Register Bank

This block is the software-visible register file shared by three identical timer channels. A simple 32-bit bus reaches it with word addresses. The block decodes each access to a channel and a register function and applies a per-field storage mask. It turns a counter-reset request into a single-cycle pulse for the addressed channel. It keeps six interrupt flags per channel that clear when read, and it drives one registered interrupt line per channel.

The channel cores sit beside the bank. They supply the live count, the event value and single-cycle flag set pulses. They consume the stored clock, counter, interval, match and event settings. The three copies of each register function share one address group and sit in adjacent words, so the channel is the word address modulo three and the function is the quotient.

Top module: `ttc_regbank`

## Requirements
- R1: For word address A below 33, the channel is A mod 3 and the function group is A div 3. The groups by quotient are: 0 clock setup, 1 counter control, 2 count value, 3 interval, 4/5/6 match 0/1/2, 7 interrupt flags, 8 interrupt enable, 9 event setup, 10 event value.
- R2: Clock setup and interrupt enable store bits 5:0 of the write data. Event setup stores bits 2:0. Interval and match store bits 15:0. Unstored bits read as zero.
- R3: A write to counter control with data bit 4 set raises cnt_clear_o for that channel only, for exactly the cycle after the write. Bit 4 is never stored and reads as zero, so the stored value is the write data masked with 0x2F.
- R4: Reading a channel's interrupt flags returns the flags held before the read and clears them. A flag set pulse in the same cycle as the read survives for the next read.
- R5: Writes to the interrupt flag words change nothing.
- R6: irq_o for a channel is high exactly when the channel's flags AND its interrupt enables are nonzero. It follows the register state with one register stage, so it changes in the same cycle as the state.
- R7: After reset, counter control reads 0x21 and every other stored register reads zero. No interrupt or clear pulse is active.
- R8: Words 33 and above read as zero, and writes to them change no register.
- R9: The count value and event value words are read-only. They return the channel's 16-bit input zero-extended to 32 bits.
- R10: rdata_o is registered. It holds the read result in the cycle after rd_en_i and is zero after a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 6 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| count_i | input | 48 | Live count, 16 bits per channel |
| event_i | input | 48 | Event value, 16 bits per channel |
| flag_set_i | input | 18 | Flag set pulses, 6 bits per channel |
| clk_ctrl_o | output | 18 | Clock setup, 6 bits per channel |
| cnt_ctrl_o | output | 18 | Counter control, 6 bits per channel |
| interval_o | output | 48 | Interval, 16 bits per channel |
| match_o | output | 144 | Match values, 3x16 bits per channel |
| ev_ctrl_o | output | 9 | Event setup, 3 bits per channel |
| cnt_clear_o | output | 3 | Counter clear pulse per channel |
| irq_o | output | 3 | Interrupt per channel |

## Verification
The hardest case is a flag set pulse landing in the same cycle as the clearing read of that channel's flags. The read must report the old flags and keep the new one. The bench drives that collision directly and also lets random sparse flag pulses coincide with random status reads. The reference model resolves each cycle in the same order: read first, then writes, then the clear and set. Because channels are interleaved, random addresses over a range slightly past the map hit all three copies of every group and the unmapped words as well.

// File: rtl/ttc_regbank_pkg.sv
package ttc_regbank_pkg;
  localparam int FLAG_W   = 6;
  localparam int EVC_W    = 3;
  localparam int N_MATCH  = 3;
  localparam int N_GROUP  = 11;
  localparam int RST_BIT  = 4;
  localparam logic [FLAG_W-1:0] CTRL_INIT = 6'h21;
  // group codes: address word div channel count
  localparam int G_CLK   = 0;
  localparam int G_CTRL  = 1;
  localparam int G_COUNT = 2;
  localparam int G_INTV  = 3;
  localparam int G_MATCH = 4;
  localparam int G_FLAG  = 7;
  localparam int G_IEN   = 8;
  localparam int G_EVC   = 9;
  localparam int G_EVV   = 10;
endpackage

// File: rtl/ttc_addr_dec.sv
module ttc_addr_dec #(
  parameter int AW  = 6,
  parameter int NCH = 3,
  parameter int NGR = 11
) (
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] chan_o,
  output logic [AW-1:0] grp_o,
  output logic          hit_o
);
  localparam int WORDS = NCH * NGR;

  always_comb begin
    chan_o = addr_i % AW'(NCH);
    grp_o  = addr_i / AW'(NCH);
    hit_o  = addr_i < AW'(WORDS);
    // R1: a decoded hit always names an existing channel and group
    a_chan_range_r1: assert (!hit_o || (chan_o < AW'(NCH) && grp_o < AW'(NGR)));
  end
endmodule

// File: rtl/ttc_chan_regs.sv
module ttc_chan_regs
  import ttc_regbank_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [AW-1:0]         grp_i,
  input  logic [CW-1:0]         wdata_i,
  input  logic [CW-1:0]         count_i,
  input  logic [CW-1:0]         event_i,
  input  logic [FLAG_W-1:0]     flag_set_i,
  output logic [FLAG_W-1:0]     clk_ctrl_o,
  output logic [FLAG_W-1:0]     cnt_ctrl_o,
  output logic [CW-1:0]         interval_o,
  output logic [N_MATCH*CW-1:0] match_o,
  output logic [EVC_W-1:0]      ev_ctrl_o,
  output logic                  clear_o,
  output logic                  irq_o,
  output logic [DW-1:0]         rval_o
);
  localparam logic [FLAG_W-1:0] CTRL_KEEP = ~(FLAG_W'(1) << RST_BIT);

  logic [FLAG_W-1:0] clk_q, ctrl_q, flag_q, ien_q, flag_nxt, ien_nxt;
  logic [CW-1:0]     intv_q;
  logic [EVC_W-1:0]  evc_q;
  logic              clr_q, irq_q;
  logic [CW-1:0]     match_q [N_MATCH];

  function automatic logic sel(input logic [AW-1:0] g, input int code);
    return g == AW'(code);
  endfunction

  always_comb begin
    flag_nxt = ((rd_i && sel(grp_i, G_FLAG)) ? '0 : flag_q) | flag_set_i;
    ien_nxt  = (wr_i && sel(grp_i, G_IEN)) ? wdata_i[FLAG_W-1:0] : ien_q;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      clk_q  <= '0;
      ctrl_q <= CTRL_INIT;
      intv_q <= '0;
      evc_q  <= '0;
      flag_q <= '0;
      ien_q  <= '0;
      clr_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      clr_q  <= wr_i && sel(grp_i, G_CTRL) && wdata_i[RST_BIT];
      flag_q <= flag_nxt;
      ien_q  <= ien_nxt;
      irq_q  <= |(flag_nxt & ien_nxt);
      if (wr_i) begin
        if (sel(grp_i, G_CLK))  clk_q  <= wdata_i[FLAG_W-1:0];
        if (sel(grp_i, G_CTRL)) ctrl_q <= wdata_i[FLAG_W-1:0] & CTRL_KEEP;
        if (sel(grp_i, G_INTV)) intv_q <= wdata_i;
        if (sel(grp_i, G_EVC))  evc_q  <= wdata_i[EVC_W-1:0];
      end
    end
  end

  for (genvar m = 0; m < N_MATCH; m++) begin : g_match
    always_ff @(posedge clk_i) begin
      if (rst_i)                                 match_q[m] <= '0;
      else if (wr_i && sel(grp_i, G_MATCH + m))  match_q[m] <= wdata_i;
    end
    assign match_o[m*CW +: CW] = match_q[m];
  end

  always_comb begin
    rval_o = '0;
    if (sel(grp_i, G_CLK))   rval_o = DW'(clk_q);
    if (sel(grp_i, G_CTRL))  rval_o = DW'(ctrl_q);
    if (sel(grp_i, G_COUNT)) rval_o = DW'(count_i);
    if (sel(grp_i, G_INTV))  rval_o = DW'(intv_q);
    for (int m = 0; m < N_MATCH; m++)
      if (sel(grp_i, G_MATCH + m)) rval_o = DW'(match_q[m]);
    if (sel(grp_i, G_FLAG))  rval_o = DW'(flag_q);
    if (sel(grp_i, G_IEN))   rval_o = DW'(ien_q);
    if (sel(grp_i, G_EVC))   rval_o = DW'(evc_q);
    if (sel(grp_i, G_EVV))   rval_o = DW'(event_i);
  end

  assign clk_ctrl_o = clk_q;
  assign cnt_ctrl_o = ctrl_q;
  assign interval_o = intv_q;
  assign ev_ctrl_o  = evc_q;
  assign clear_o    = clr_q;
  assign irq_o      = irq_q;

  p_ctrl_bit_zero_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    !ctrl_q[RST_BIT]);
  p_clear_cause_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    clr_q |-> $past(wr_i && sel(grp_i, G_CTRL) && wdata_i[RST_BIT]));
  p_flag_cleared_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_i && sel(grp_i, G_FLAG) && flag_set_i == '0) |=> flag_q == '0);
  p_flag_no_write_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_i && !rd_i && sel(grp_i, G_FLAG) && flag_set_i == '0) |=> $stable(flag_q));
  p_irq_state_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_q == |(flag_q & ien_q));
endmodule

// File: rtl/ttc_read_mux.sv
module ttc_read_mux #(
  parameter int AW  = 6,
  parameter int DW  = 32,
  parameter int NCH = 3
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              rd_i,
  input  logic              hit_i,
  input  logic [AW-1:0]     chan_i,
  input  logic [NCH*DW-1:0] rvals_i,
  output logic [DW-1:0]     rdata_o
);
  logic [DW-1:0] pick;

  always_comb begin
    pick = '0;
    for (int c = 0; c < NCH; c++)
      if (chan_i == AW'(c)) pick = rvals_i[c*DW +: DW];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)                rdata_o <= '0;
    else if (rd_i && hit_i)   rdata_o <= pick;
    else                      rdata_o <= '0;
  end

  p_unmapped_zero_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_i && !hit_i) |=> rdata_o == '0);
  p_idle_zero_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    !rd_i |=> rdata_o == '0);
endmodule

// File: rtl/ttc_regbank.sv
module ttc_regbank
  import ttc_regbank_pkg::*;
#(
  parameter int AW  = 6,
  parameter int DW  = 32,
  parameter int CW  = 16,
  parameter int NCH = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_i,
  input  logic                      wr_en_i,
  input  logic                      rd_en_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [DW-1:0]             wdata_i,
  output logic [DW-1:0]             rdata_o,
  input  logic [NCH*CW-1:0]         count_i,
  input  logic [NCH*CW-1:0]         event_i,
  input  logic [NCH*FLAG_W-1:0]     flag_set_i,
  output logic [NCH*FLAG_W-1:0]     clk_ctrl_o,
  output logic [NCH*FLAG_W-1:0]     cnt_ctrl_o,
  output logic [NCH*CW-1:0]         interval_o,
  output logic [NCH*N_MATCH*CW-1:0] match_o,
  output logic [NCH*EVC_W-1:0]      ev_ctrl_o,
  output logic [NCH-1:0]            cnt_clear_o,
  output logic [NCH-1:0]            irq_o
);
  logic [AW-1:0]     chan, grp;
  logic              hit;
  logic [NCH*DW-1:0] rvals;

  ttc_addr_dec #(.AW(AW), .NCH(NCH), .NGR(N_GROUP)) u_dec (
    .addr_i(addr_i), .chan_o(chan), .grp_o(grp), .hit_o(hit)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic here;
    assign here = hit && chan == AW'(c);
    ttc_chan_regs #(.AW(AW), .DW(DW), .CW(CW)) u_ch (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .wr_i       (wr_en_i && here),
      .rd_i       (rd_en_i && here),
      .grp_i      (grp),
      .wdata_i    (wdata_i[CW-1:0]),
      .count_i    (count_i[c*CW +: CW]),
      .event_i    (event_i[c*CW +: CW]),
      .flag_set_i (flag_set_i[c*FLAG_W +: FLAG_W]),
      .clk_ctrl_o (clk_ctrl_o[c*FLAG_W +: FLAG_W]),
      .cnt_ctrl_o (cnt_ctrl_o[c*FLAG_W +: FLAG_W]),
      .interval_o (interval_o[c*CW +: CW]),
      .match_o    (match_o[c*N_MATCH*CW +: N_MATCH*CW]),
      .ev_ctrl_o  (ev_ctrl_o[c*EVC_W +: EVC_W]),
      .clear_o    (cnt_clear_o[c]),
      .irq_o      (irq_o[c]),
      .rval_o     (rvals[c*DW +: DW])
    );
  end

  ttc_read_mux #(.AW(AW), .DW(DW), .NCH(NCH)) u_rd (
    .clk_i(clk_i), .rst_i(rst_i), .rd_i(rd_en_i), .hit_i(hit),
    .chan_i(chan), .rvals_i(rvals), .rdata_o(rdata_o)
  );

  p_clear_onehot_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(cnt_clear_o));
endmodule

// File: tb/ttc_regbank_bench.sv
`timescale 1ns/1ps
module ttc_regbank_bench;
  logic         clk = 0, rst = 1;
  logic         wr_en = 0, rd_en = 0;
  logic [5:0]   addr = 0;
  logic [31:0]  wdata = 0;
  logic [31:0]  rdata;
  logic [47:0]  count_v = 0, event_v = 0;
  logic [17:0]  fset = 0;
  logic [17:0]  clk_ctrl, cnt_ctrl;
  logic [47:0]  interval;
  logic [143:0] match;
  logic [8:0]   ev_ctrl;
  logic [2:0]   clr, irq;

  always #2 clk = ~clk;

  ttc_regbank u_ttc_regbank (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .count_i(count_v), .event_i(event_v),
    .flag_set_i(fset), .clk_ctrl_o(clk_ctrl), .cnt_ctrl_o(cnt_ctrl),
    .interval_o(interval), .match_o(match), .ev_ctrl_o(ev_ctrl),
    .cnt_clear_o(clr), .irq_o(irq)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  logic [5:0]  m_clk [3], m_ctrl [3], m_flag [3], m_ien [3];
  logic [15:0] m_intv [3];
  logic [15:0] m_match [3][3];
  logic [2:0]  m_evc [3];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input int a);
    int ch, g;
    if (a >= 33) return 0;
    ch = a % 3; g = a / 3;
    case (g)
      0: return 32'(m_clk[ch]);
      1: return 32'(m_ctrl[ch]);
      2: return 32'(count_v[ch*16 +: 16]);
      3: return 32'(m_intv[ch]);
      4, 5, 6: return 32'(m_match[ch][g-4]);
      7: return 32'(m_flag[ch]);
      8: return 32'(m_ien[ch]);
      9: return 32'(m_evc[ch]);
      default: return 32'(event_v[ch*16 +: 16]);
    endcase
  endfunction

  function automatic string req_of(input int a);
    if (a >= 33) return "R8";
    case (a / 3)
      0, 8, 9, 3, 4, 5, 6: return "R2";
      1: return "R3";
      2, 10: return "R9";
      default: return "R4";
    endcase
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 3; c++) begin
      m_clk[c] = 0; m_ctrl[c] = 6'h21; m_flag[c] = 0; m_ien[c] = 0;
      m_intv[c] = 0; m_evc[c] = 0;
      for (int m = 0; m < 3; m++) m_match[c][m] = 0;
    end
  endtask

  // one bus cycle: drive on negedge, check just after the next posedge
  task automatic op(input bit w, input bit r, input int a, input logic [31:0] d, input logic [17:0] s);
    logic [31:0] exp_rd;
    logic [2:0]  exp_clr;
    int ch, g;
    @(negedge clk);
    wr_en = w; rd_en = r; addr = 6'(a); wdata = d; fset = s;
    exp_rd = r ? exp_read(a) : 32'h0;
    exp_clr = 0;
    ch = a % 3; g = a / 3;
    if (w && a < 33) begin
      case (g)
        0: m_clk[ch] = d[5:0];
        1: begin m_ctrl[ch] = d[5:0] & 6'h2F; exp_clr[ch] = d[4]; end
        3: m_intv[ch] = d[15:0];
        4, 5, 6: m_match[ch][g-4] = d[15:0];
        8: m_ien[ch] = d[5:0];
        9: m_evc[ch] = d[2:0];
        default: ;
      endcase
    end
    for (int c = 0; c < 3; c++) begin
      if (r && a < 33 && g == 7 && ch == c) m_flag[c] = 0;
      m_flag[c] |= s[c*6 +: 6];
    end
    @(posedge clk); #1;
    if (r) check(rdata == exp_rd, req_of(a), rdata, exp_rd);
    else   check(rdata == 0, "R10", rdata, 0);
    check(clr == exp_clr, "R3", 32'(clr), 32'(exp_clr));
    for (int c = 0; c < 3; c++)
      check(irq[c] == |(m_flag[c] & m_ien[c]), "R6", 32'(irq[c]), 32'(|(m_flag[c] & m_ien[c])));
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    count_v = 48'h1234_abcd_5678; event_v = 48'h0f0f_a5a5_c3c3;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R7: reset state of every word, R1 decode order
    for (int a = 0; a < 36; a++) op(0, 1, a, 0, 0);
    check(cnt_ctrl == {3{6'h21}}, "R7", 32'(cnt_ctrl), 32'(18'h21861));
    // R3: clear pulse on channel 1 only, bit 4 dropped
    op(1, 0, 4, 32'hFFFF_FF1F, 0);
    op(0, 1, 4, 0, 0);
    // R2: masks on clock setup, enable, event setup, match
    op(1, 0, 2, 32'hFFFF_FFFF, 0); op(0, 1, 2, 0, 0);
    op(1, 0, 26, 32'hFFFF_FFC5, 0); op(0, 1, 26, 0, 0);
    op(1, 0, 29, 32'hFFFF_FFFE, 0); op(0, 1, 29, 0, 0);
    op(1, 0, 19, 32'hBEEF_CAFE, 0); op(0, 1, 19, 0, 0);
    // R6: flag with enable on channel 2
    op(0, 0, 0, 0, 18'h01 << 12);
    // R5: write to flag word ignored
    op(1, 0, 23, 32'h3F, 0); op(0, 1, 23, 0, 0);
    // R4: set on channel 1 flag in same cycle as its clearing read
    op(0, 0, 0, 0, 18'h08 << 6);
    op(0, 1, 22, 0, 18'h02 << 6);
    op(0, 1, 22, 0, 0);
    op(0, 1, 22, 0, 0);
    // R8: unmapped write then read everything back
    op(1, 0, 40, 32'hFFFF_FFFF, 0); op(0, 1, 40, 0, 0);
    op(1, 0, 33, 32'hFFFF_FFFF, 0);
    for (int a = 0; a < 33; a++) op(0, 1, a, 0, 0);
    // R9: read-only value words ignore writes
    op(1, 0, 7, 32'hFFFF, 0); op(1, 0, 31, 32'hFFFF, 0);
    op(0, 1, 7, 0, 0); op(0, 1, 31, 0, 0);
    // random mix
    for (int i = 0; i < 1500; i++) begin
      int k, a;
      logic [17:0] s;
      k = int'($urandom % 4);
      a = int'($urandom % 40);
      s = ($urandom % 4 == 0) ? 18'($urandom) : 18'h0;
      if ($urandom % 16 == 0) begin count_v = {$urandom, $urandom}; event_v = {$urandom, $urandom}; end
      case (k)
        0: op(1, 0, a, $urandom, s);
        1: op(0, 1, a, 0, s);
        2: op(0, 1, 21 + int'($urandom % 3), 0, s);
        default: op(1, 0, 24 + int'($urandom % 3), $urandom, s);
      endcase
    end
    for (int a = 0; a < 33; a++) op(0, 1, a, 0, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule